// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block is the device-side status logic of a NOR-style flash model. While an internal program or erase algorithm runs, a host read returns a status byte instead of array contents. The host polls that byte to follow the algorithm. It tells a running algorithm from an idle one by watching a global toggle bit. It tells which sectors are part of an erase by watching a per-sector toggle bit. It reads a latched failure flag and an erase-started flag directly. When no algorithm runs and no failure is latched, reads pass the array data straight through.

Algorithm progress comes from stimulus inputs. A program-start pulse, sector-erase and chip-erase start pulses, a completion pulse, a pulse-count overflow, an erase-suspend level and a read/reset command pulse drive an internal state machine. The per-sector select and protect vectors set the effective erase set when an erase starts. The sector of a read is the top `SECT_W` bits of the read address. The protected-sector interval is counted in clock cycles: `CLK_MHZ * PROT_US`.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, and while no algorithm runs and no failure is latched, `dout_o` equals `array_data_i`, and reads there do not change either toggle bit.
- R2: Status byte bit 6 resets to 0. It inverts on each clock edge with `rd_i` high while a program, a sector-erase window, an active erase, a protected hold or a latched failure is present.
- R3: Status bit 2 inverts on a read edge only when the read sector is in the effective erase set. This applies in the erase window, the active erase, erase suspend and failure. It never moves during a program.
- R4: While `suspend_i` is high during an active erase, bit 6 is frozen. Reads of sectors in the erase set show the status byte, and other reads return `array_data_i`. Dropping `suspend_i` resumes the erase.
- R5: The effective erase set is selected & ~protected. If it is empty when an erase starts, the status byte is shown with bit 6 toggling for exactly `CLK_MHZ*PROT_US` cycles. Array read then returns.
- R6: `pulse_ovf_i` during a program or an active (unsuspended) erase latches failure, and bit 5 of the status byte becomes 1.
- R7: A program start whose data has a 1 where the cell data holds 0 latches failure at once.
- R8: A latched failure persists, ignoring `alg_done_i`, until `read_reset_i`. That command returns the block to array read; elsewhere it is ignored.
- R9: Bit 3 reads 0 for `ERASE_WIN_CYC` cycles after a sector-erase start and 1 once the erase begins. A chip erase shows 1 from its first status cycle.
- R10: `alg_done_i` ends a program or active erase and returns array read. Status byte bits 7, 4, 1 and 0 always read 0.
- R11: Start pulses are acted on only in array-read state. Priority is program, then sector erase, then chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read cycle strobe, one per read |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | 8 | Array contents for the read address |
| prog_start_i | input | 1 | Program command accepted |
| prog_data_i | input | 8 | Data being programmed |
| cell_data_i | input | 8 | Current cell contents at program address |
| serase_start_i | input | 1 | Sector erase command accepted |
| cerase_start_i | input | 1 | Chip erase command accepted |
| erase_sel_i | input | 2**SECT_W | Sectors selected for erase |
| sect_prot_i | input | 2**SECT_W | Protected sectors |
| suspend_i | input | 1 | Erase suspend request (level) |
| pulse_ovf_i | input | 1 | Internal pulse count limit exceeded |
| alg_done_i | input | 1 | Algorithm completed |
| read_reset_i | input | 1 | Read/Reset command |
| dout_o | output | 8 | Read data or status byte |

## Verification
The bench alternates reads between selected, protected-selected and unselected sectors. A design that tests the raw select vector instead of the effective set would toggle bit 2 on the protected sector. During suspend it checks that bit 6 freezes while bit 2 keeps moving and unselected sectors return array data; a design that froze bit 2 as well, or showed status everywhere, diverges at once. It counts the erase window and the protected hold to the exact cycle, so an off-by-one in either counter is caught. It sends completion, start and read/reset pulses in states that must ignore them, exposing any state that leaks out of the failure latch or re-arms mid-algorithm.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int DQ_W     = 8;
  localparam int TGL1_BIT = 6;
  localparam int FAIL_BIT = 5;
  localparam int ETMR_BIT = 3;
  localparam int TGL2_BIT = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_EWAIT = 3'd2,
    ST_ERASE = 3'd3,
    ST_SUSP  = 3'd4,
    ST_HOLD  = 3'd5,
    ST_FAIL  = 3'd6
  } alg_st_e;
endpackage

// File: rtl/flash_sect_hit.sv
module flash_sect_hit #(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 3,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_SECT-1:0] mask_i,
  output logic                hit_o
);
  logic [SECT_W-1:0]   sect_idx;
  logic [NUM_SECT-1:0] sect_onehot;

  assign sect_idx = addr_i[ADDR_W-1 -: SECT_W];

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    assign sect_onehot[s] = (sect_idx == SECT_W'(s)) & mask_i[s];
  end

  assign hit_o = |sect_onehot;
endmodule

// File: rtl/flash_alg_fsm.sv
module flash_alg_fsm
  import flash_stat_pkg::*;
#(
  parameter int SECT_W        = 3,
  parameter int ERASE_WIN_CYC = 12500,
  parameter int PROT_HOLD_CYC = 25000,
  localparam int NUM_SECT = 1 << SECT_W,
  localparam int CNT_MAX  = (ERASE_WIN_CYC > PROT_HOLD_CYC) ? ERASE_WIN_CYC : PROT_HOLD_CYC,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prog_start_i,
  input  logic [DQ_W-1:0]     prog_data_i,
  input  logic [DQ_W-1:0]     cell_data_i,
  input  logic                serase_start_i,
  input  logic                cerase_start_i,
  input  logic [NUM_SECT-1:0] erase_sel_i,
  input  logic [NUM_SECT-1:0] sect_prot_i,
  input  logic                suspend_i,
  input  logic                pulse_ovf_i,
  input  logic                alg_done_i,
  input  logic                read_reset_i,
  output alg_st_e             state_o,
  output logic [NUM_SECT-1:0] mask_o
);
  alg_st_e             st_q, st_d;
  logic [NUM_SECT-1:0] mask_q, mask_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [NUM_SECT-1:0] sect_eff, chip_eff;
  logic                zero_over_one;

  assign sect_eff      = erase_sel_i & ~sect_prot_i;
  assign chip_eff      = ~sect_prot_i;
  assign zero_over_one = |(prog_data_i & ~cell_data_i);

  always_comb begin
    st_d   = st_q;
    mask_d = mask_q;
    cnt_d  = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d  = '0;
        mask_d = '0;
        if (prog_start_i) begin
          st_d = zero_over_one ? ST_FAIL : ST_PROG;
        end else if (serase_start_i) begin
          mask_d = sect_eff;
          st_d   = (|sect_eff) ? ST_EWAIT : ST_HOLD;
        end else if (cerase_start_i) begin
          mask_d = chip_eff;
          st_d   = (|chip_eff) ? ST_ERASE : ST_HOLD;
        end
      end
      ST_PROG: begin
        if (pulse_ovf_i)     st_d = ST_FAIL;
        else if (alg_done_i) st_d = ST_IDLE;
      end
      ST_EWAIT: begin
        if (cnt_q == CNT_W'(ERASE_WIN_CYC - 1)) begin
          st_d  = ST_ERASE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ERASE: begin
        if (pulse_ovf_i)     st_d = ST_FAIL;
        else if (suspend_i)  st_d = ST_SUSP;
        else if (alg_done_i) st_d = ST_IDLE;
      end
      ST_SUSP: begin
        if (!suspend_i) st_d = ST_ERASE;
      end
      ST_HOLD: begin
        if (cnt_q == CNT_W'(PROT_HOLD_CYC - 1)) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FAIL: begin
        if (read_reset_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (st_d == ST_IDLE) mask_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign mask_o  = mask_q;

  // R8
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FAIL && !read_reset_i) |=> (st_q == ST_FAIL));

  // R5
  hold_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> (mask_q == '0));

  // R9
  ewait_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EWAIT) |-> (cnt_q < CNT_W'(ERASE_WIN_CYC)));

  // R4
  susp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP && !suspend_i) |=> (st_q == ST_ERASE));

  // R11
  busy_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_PROG, ST_EWAIT, ST_ERASE, ST_SUSP}) && (st_d != ST_IDLE) |=> $stable(mask_q));
endmodule

// File: rtl/flash_toggle_gen.sv
module flash_toggle_gen
  import flash_stat_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rd_i,
  input  alg_st_e state_i,
  input  logic    hit_i,
  output logic    tgl_all_o,
  output logic    tgl_sect_o
);
  logic t6_q, t2_q;
  logic t6_act, t2_act;

  assign t6_act = state_i inside {ST_PROG, ST_EWAIT, ST_ERASE, ST_HOLD, ST_FAIL};
  assign t2_act = hit_i && (state_i inside {ST_EWAIT, ST_ERASE, ST_SUSP, ST_FAIL});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else if (rd_i) begin
      if (t6_act) t6_q <= ~t6_q;
      if (t2_act) t2_q <= ~t2_q;
    end
  end

  assign tgl_all_o  = t6_q;
  assign tgl_sect_o = t2_q;

  // R2
  t6_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(t6_q));

  // R4
  t6_susp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SUSP) |=> $stable(t6_q));

  // R3
  t2_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(t2_q));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int SECT_W        = 3,
  parameter int CLK_MHZ       = 250,
  parameter int PROT_US       = 100,
  parameter int ERASE_WIN_CYC = 12500,
  localparam int NUM_SECT      = 1 << SECT_W,
  localparam int PROT_HOLD_CYC = CLK_MHZ * PROT_US
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [DQ_W-1:0]     array_data_i,
  input  logic                prog_start_i,
  input  logic [DQ_W-1:0]     prog_data_i,
  input  logic [DQ_W-1:0]     cell_data_i,
  input  logic                serase_start_i,
  input  logic                cerase_start_i,
  input  logic [NUM_SECT-1:0] erase_sel_i,
  input  logic [NUM_SECT-1:0] sect_prot_i,
  input  logic                suspend_i,
  input  logic                pulse_ovf_i,
  input  logic                alg_done_i,
  input  logic                read_reset_i,
  output logic [DQ_W-1:0]     dout_o
);
  alg_st_e             state;
  logic [NUM_SECT-1:0] mask;
  logic                hit, t6, t2;
  logic                show_stat, etmr;
  logic [DQ_W-1:0]     stat_byte;

  flash_alg_fsm #(
    .SECT_W       (SECT_W),
    .ERASE_WIN_CYC(ERASE_WIN_CYC),
    .PROT_HOLD_CYC(PROT_HOLD_CYC)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .prog_start_i  (prog_start_i),
    .prog_data_i   (prog_data_i),
    .cell_data_i   (cell_data_i),
    .serase_start_i(serase_start_i),
    .cerase_start_i(cerase_start_i),
    .erase_sel_i   (erase_sel_i),
    .sect_prot_i   (sect_prot_i),
    .suspend_i     (suspend_i),
    .pulse_ovf_i   (pulse_ovf_i),
    .alg_done_i    (alg_done_i),
    .read_reset_i  (read_reset_i),
    .state_o       (state),
    .mask_o        (mask)
  );

  flash_sect_hit #(
    .ADDR_W(ADDR_W),
    .SECT_W(SECT_W)
  ) u_hit (
    .addr_i(rd_addr_i),
    .mask_i(mask),
    .hit_o (hit)
  );

  flash_toggle_gen u_tgl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .state_i   (state),
    .hit_i     (hit),
    .tgl_all_o (t6),
    .tgl_sect_o(t2)
  );

  assign etmr = (state inside {ST_ERASE, ST_SUSP}) || (state == ST_FAIL && |mask);

  always_comb begin
    stat_byte           = '0;
    stat_byte[TGL1_BIT] = t6;
    stat_byte[FAIL_BIT] = (state == ST_FAIL);
    stat_byte[ETMR_BIT] = etmr;
    stat_byte[TGL2_BIT] = t2;
  end

  assign show_stat = (state != ST_IDLE) && !(state == ST_SUSP && !hit);
  assign dout_o    = show_stat ? stat_byte : array_data_i;

  // R1
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (dout_o == array_data_i));

  // R6
  fail_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state) == ST_PROG && $past(pulse_ovf_i)) |-> dout_o[FAIL_BIT]);
endmodule

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
  localparam int ADDR_W  = 12;
  localparam int SECT_W  = 3;
  localparam int NS      = 1 << SECT_W;
  localparam int CLK_MHZ = 250;
  localparam int PROT_US = 1;
  localparam int EWIN    = 16;
  localparam int HOLD    = CLK_MHZ * PROT_US;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [7:0]        array_data_i = '0;
  logic              prog_start_i = 1'b0;
  logic [7:0]        prog_data_i = '0;
  logic [7:0]        cell_data_i = '0;
  logic              serase_start_i = 1'b0;
  logic              cerase_start_i = 1'b0;
  logic [NS-1:0]     erase_sel_i = '0;
  logic [NS-1:0]     sect_prot_i = '0;
  logic              suspend_i = 1'b0;
  logic              pulse_ovf_i = 1'b0;
  logic              alg_done_i = 1'b0;
  logic              read_reset_i = 1'b0;
  logic [7:0]        dout_o;

  always #2 clk = ~clk;

  flash_status_gen #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .CLK_MHZ(CLK_MHZ),
    .PROT_US(PROT_US), .ERASE_WIN_CYC(EWIN)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .rd_addr_i(rd_addr_i),
    .array_data_i(array_data_i), .prog_start_i(prog_start_i),
    .prog_data_i(prog_data_i), .cell_data_i(cell_data_i),
    .serase_start_i(serase_start_i), .cerase_start_i(cerase_start_i),
    .erase_sel_i(erase_sel_i), .sect_prot_i(sect_prot_i),
    .suspend_i(suspend_i), .pulse_ovf_i(pulse_ovf_i),
    .alg_done_i(alg_done_i), .read_reset_i(read_reset_i), .dout_o(dout_o)
  );

  // reference model: 0 idle 1 prog 2 window 3 erase 4 suspend 5 hold 6 fail
  int      m_st = 0;
  int      m_cnt = 0;
  bit [NS-1:0] m_set = '0;
  bit      m_t6 = 0, m_t2 = 0;
  int      n_cmp = 0, n_bad = 0;
  int      cyc_cnt = 0;
  bit      finished = 0;

  function automatic int sect_of(logic [ADDR_W-1:0] a);
    return int'(a >> (ADDR_W - SECT_W));
  endfunction

  function automatic logic [7:0] m_out();
    logic [7:0] b;
    bit in_set;
    in_set = m_set[sect_of(rd_addr_i)];
    if (m_st == 0 || (m_st == 4 && !in_set)) return array_data_i;
    b = 8'h00;
    b[6] = m_t6;
    b[5] = (m_st == 6);
    b[3] = (m_st == 3 || m_st == 4 || (m_st == 6 && m_set != 0));
    b[2] = m_t2;
    return b;
  endfunction

  task automatic m_step();
    bit in_set;
    in_set = m_set[sect_of(rd_addr_i)];
    if (rd_i && (m_st == 1 || m_st == 2 || m_st == 3 || m_st == 5 || m_st == 6)) m_t6 = !m_t6;
    if (rd_i && in_set && (m_st == 2 || m_st == 3 || m_st == 4 || m_st == 6)) m_t2 = !m_t2;
    case (m_st)
      0: begin
        m_cnt = 0;
        if (prog_start_i) m_st = ((prog_data_i & ~cell_data_i) != 0) ? 6 : 1;
        else if (serase_start_i) begin
          m_set = erase_sel_i & ~sect_prot_i;
          m_st = (m_set != 0) ? 2 : 5;
        end else if (cerase_start_i) begin
          m_set = ~sect_prot_i;
          m_st = (m_set != 0) ? 3 : 5;
        end
      end
      1: if (pulse_ovf_i) m_st = 6; else if (alg_done_i) m_st = 0;
      2: begin m_cnt++; if (m_cnt == EWIN) begin m_st = 3; m_cnt = 0; end end
      3: if (pulse_ovf_i) m_st = 6; else if (suspend_i) m_st = 4; else if (alg_done_i) m_st = 0;
      4: if (!suspend_i) m_st = 3;
      5: begin m_cnt++; if (m_cnt == HOLD) begin m_st = 0; m_cnt = 0; end end
      6: if (read_reset_i) m_st = 0;
      default: m_st = 0;
    endcase
    if (m_st == 0) m_set = '0;
  endtask

  task automatic cyc(string tag);
    logic [7:0] exp_v;
    #1;
    exp_v = m_out();
    n_cmp++;
    if (dout_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%02h expected=%02h", tag, $time, dout_o, exp_v);
    end
    @(posedge clk);
    if (rst_ni) m_step();
    @(negedge clk);
    cyc_cnt++;
  endtask

  task automatic clr_pulses();
    prog_start_i = 0; serase_start_i = 0; cerase_start_i = 0;
    pulse_ovf_i = 0; alg_done_i = 0; read_reset_i = 0;
  endtask

  task automatic reads(int n, int sa, int sb, string tag);
    for (int i = 0; i < n; i++) begin
      rd_i = (i % 4 != 3);
      rd_addr_i = {3'((i % 2) ? sb : sa), 9'(i * 7 + 5)};
      array_data_i = 8'(i * 29 + 3);
      cyc(tag);
    end
    rd_i = 0;
  endtask

  task automatic pulse_cyc(string tag);
    cyc(tag);
    clr_pulses();
  endtask

  initial begin
    @(negedge clk);
    // reset state
    reads(4, 0, 3, "R1");
    rst_ni = 1;
    reads(12, 2, 7, "R1");

    // clean program, start pulses ignored mid-algorithm
    prog_start_i = 1; prog_data_i = 8'h0F; cell_data_i = 8'hFF;
    pulse_cyc("R2");
    reads(9, 1, 4, "R2");
    serase_start_i = 1; erase_sel_i = 8'hFF; rd_i = 1;
    pulse_cyc("R11");
    reads(5, 0, 5, "R3");
    alg_done_i = 1;
    pulse_cyc("R10");
    reads(4, 6, 1, "R10");

    // program overflow then failure hold
    prog_start_i = 1; prog_data_i = 8'h00; cell_data_i = 8'h55;
    pulse_cyc("R2");
    reads(3, 2, 3, "R2");
    pulse_ovf_i = 1;
    pulse_cyc("R6");
    reads(5, 2, 3, "R6");
    alg_done_i = 1;
    pulse_cyc("R8");
    reads(3, 1, 2, "R8");
    read_reset_i = 1;
    pulse_cyc("R8");
    reads(3, 1, 2, "R8");
    read_reset_i = 1;
    pulse_cyc("R8");

    // program 1 over 0
    prog_start_i = 1; prog_data_i = 8'h80; cell_data_i = 8'h7F;
    pulse_cyc("R7");
    reads(5, 0, 7, "R7");
    read_reset_i = 1;
    pulse_cyc("R8");

    // sector erase with one protected selected sector
    erase_sel_i = 8'h06; sect_prot_i = 8'h04;
    serase_start_i = 1;
    pulse_cyc("R9");
    reads(EWIN + 4, 1, 2, "R9");
    reads(8, 1, 2, "R3");
    suspend_i = 1;
    reads(3, 1, 5, "R4");
    alg_done_i = 1; pulse_ovf_i = 1;
    pulse_cyc("R4");
    reads(8, 1, 5, "R4");
    suspend_i = 0;
    reads(4, 1, 0, "R4");
    cerase_start_i = 1; prog_start_i = 1;
    pulse_cyc("R11");
    reads(3, 1, 2, "R11");
    pulse_ovf_i = 1;
    pulse_cyc("R6");
    reads(5, 1, 2, "R6");
    read_reset_i = 1;
    pulse_cyc("R8");
    reads(3, 1, 2, "R8");

    // all selected sectors protected
    erase_sel_i = 8'h30; sect_prot_i = 8'h30;
    serase_start_i = 1;
    pulse_cyc("R5");
    reads(HOLD + 6, 4, 5, "R5");

    // chip erase
    sect_prot_i = 8'h01;
    cerase_start_i = 1;
    pulse_cyc("R9");
    reads(6, 0, 3, "R9");
    suspend_i = 1;
    reads(4, 0, 6, "R4");
    suspend_i = 0;
    reads(2, 0, 6, "R4");
    alg_done_i = 1;
    pulse_cyc("R10");
    reads(4, 0, 6, "R10");

    // chip erase with every sector protected
    sect_prot_i = 8'hFF;
    cerase_start_i = 1;
    pulse_cyc("R5");
    reads(HOLD + 3, 7, 0, "R5");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule